// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a byte-wide serial peripheral master behind a small 32-bit register port. Software fills a transmit queue through a data port, picks the clock polarity, clock phase and bit order, and chooses a target through an active-low select register. The serial engine then shifts each queued byte out on `mosi` and shifts one byte in from `miso` for every byte it sends. Each received byte goes into a receive queue, which software reads through a second data port. A dummy byte is still needed to clock in a reply.

A hold bit lets software load several bytes before any clock edge appears. When the bit is cleared, the engine sends the whole queue with only a one-cycle gap between bytes. A loopback bit feeds the outgoing bit stream back to the receiver, so the data path can be tested without a target. Software can also reset the whole core, or empty either queue, by writing to the register port.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control word (offset 0x60) reads 0x180, status (0x64) reads 0x05, the select register (0x70) reads all ones, `ss_n` is all ones and `sclk` is 0.
- R2: Control bits are 0 loopback, 1 enable, 2 master, 3 clock polarity, 4 clock phase, 5 flush transmit queue, 6 flush receive queue, 7 manual select, 8 hold, 9 LSB first. Bits 0-4 and 7-9 read back as written.
- R3: With manual select (bit 7) set, `ss_n` equals the select register. With it clear, `ss_n` is all ones while idle and equals the select register while a byte is shifting.
- R4: While the hold bit (8) is set, bytes written to the transmit port (0x68) stay queued and `sclk` does not toggle. Clearing the bit drains the queue.
- R5: Each half period of `sclk` lasts CLK_DIV system clocks, so 16 edges of one byte span 15*CLK_DIV clocks. `sclk` rests at the polarity bit between bytes.
- R6: With phase 0, each data bit is on `mosi` before its leading edge and is sampled on that edge. With phase 1, data changes on leading edges and is sampled on trailing edges. All four polarity/phase pairs work.
- R7: Bit 9 clear sends and receives MSB first; set, LSB first.
- R8: Every byte shifted out places exactly one byte in the receive queue, read at 0x6C. In loopback (bit 0) that byte equals the byte sent, and `miso` is ignored.
- R9: Writing a 1 to bit 5 or 6 empties the matching queue. That bit reads 0 again one cycle later, and the other control bits keep the written values.
- R10: The transmit queue holds FIFO_DEPTH bytes. Status bit 3 flags it full, and writes made while it is full are dropped.
- R11: Status bit 1 flags a full receive queue, and bytes received while it is full are dropped. Reading 0x6C while the queue is empty (status bit 0) returns 0 and leaves the status unchanged.
- R12: Writing exactly 0x0A to offset 0x40 returns the core to its reset state. Any other value written there has no effect.
- R13: No shifting starts unless both enable (bit 1) and master (bit 2) are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low target selects |

## Verification
The hardest states to reach from the ports are the sample and shift edges in each of the four clock modes. The first bit of a phase-0 byte must already be on `miso` before any edge. The bench therefore models a target that watches every `sclk` edge, counts edges within a byte, captures `mosi` on the sampling edges and moves `miso` on the shifting edges. A sweep covers all 16 combinations of polarity, phase, bit order and loopback, with the expected bytes and edge spacing computed arithmetically. Queue-full cases are reached by holding the engine while the transmit queue overfills, and then letting it drain into a receive queue that is never read.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [7:0] A_SWRST = 8'h40;
  localparam logic [7:0] A_CTRL  = 8'h60;
  localparam logic [7:0] A_STAT  = 8'h64;
  localparam logic [7:0] A_TXD   = 8'h68;
  localparam logic [7:0] A_RXD   = 8'h6C;
  localparam logic [7:0] A_SSEL  = 8'h70;

  localparam int C_LOOP  = 0;
  localparam int C_EN    = 1;
  localparam int C_MST   = 2;
  localparam int C_CPOL  = 3;
  localparam int C_CPHA  = 4;
  localparam int C_TXRST = 5;
  localparam int C_RXRST = 6;
  localparam int C_MANSS = 7;
  localparam int C_HOLD  = 8;
  localparam int C_LSB   = 9;
  localparam int CTRL_W  = 10;

  localparam logic [CTRL_W-1:0] CTRL_RST  = 10'h180;
  localparam logic [31:0]       SWRST_KEY = 32'h0000_000A;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
    logic loopb;
  } spim_mode_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLK_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  spim_mode_t    mode,
  input  logic [DW-1:0] tx_word,
  output logic          tx_pop,
  output logic [DW-1:0] rx_word,
  output logic          rx_push,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          busy
);
  localparam int HALVES = 2 * DW;
  localparam int HW     = $clog2(HALVES);
  localparam int DVW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          busy_q, busy_d;
  logic          sclk_q, sclk_d;
  logic [DVW-1:0] div_q, div_d;
  logic [HW-1:0] half_q, half_d;
  logic [DW-1:0] tx_sh_q, tx_sh_d;
  logic [DW-1:0] rx_sh_q, rx_sh_d;
  logic [DW-1:0] tx_ord, rx_full;
  logic          tick, leading, last, samp, shft, din, start;

  assign tick    = (div_q == DVW'(CLK_DIV - 1));
  assign leading = ~half_q[0];
  assign last    = (half_q == HW'(HALVES - 1));
  assign samp    = mode.cpha ? ~leading : leading;
  assign shft    = mode.cpha ? (leading && (half_q != '0)) : ~leading;
  assign din     = mode.loopb ? tx_sh_q[DW-1] : miso;
  assign start   = go && !busy_q && !clr;
  assign rx_full = mode.cpha ? {rx_sh_q[DW-2:0], din} : rx_sh_q;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      tx_ord[i]  = mode.lsb ? tx_word[DW-1-i] : tx_word[i];
      rx_word[i] = mode.lsb ? rx_full[DW-1-i] : rx_full[i];
    end
  end

  always_comb begin
    busy_d  = busy_q;
    sclk_d  = sclk_q;
    div_d   = div_q;
    half_d  = half_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    if (clr || !busy_q) begin
      sclk_d = mode.cpol;
      div_d  = '0;
      half_d = '0;
      busy_d = 1'b0;
      if (start) begin
        busy_d  = 1'b1;
        tx_sh_d = tx_ord;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        sclk_d = ~sclk_q;
        half_d = last ? '0 : half_q + 1'b1;
        if (samp) rx_sh_d = {rx_sh_q[DW-2:0], din};
        if (shft) tx_sh_d = {tx_sh_q[DW-2:0], 1'b0};
        if (last) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      div_q   <= '0;
      half_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      busy_q  <= busy_d;
      sclk_q  <= sclk_d;
      div_q   <= div_d;
      half_q  <= half_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
    end
  end

  assign tx_pop  = start;
  assign rx_push = busy_q && tick && last && !clr;
  assign sclk    = sclk_q;
  assign mosi    = tx_sh_q[DW-1];
  assign busy    = busy_q;

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2,
  parameter int NUM_SS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_SS-1:0] ss_q, ss_d;
  logic              wr, rd, ctrl_wr, sw_rst;
  logic              tx_push, tx_pop, tx_empty, tx_full, tx_flush;
  logic              rx_push, rx_pop, rx_empty, rx_full, rx_flush;
  logic [DW-1:0]     tx_dout, rx_dout, rx_word;
  logic              go, eng_busy;
  spim_mode_t        eng_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign ctrl_wr = wr && (bus_addr == A_CTRL);
  assign sw_rst  = wr && (bus_addr == A_SWRST) && (bus_wdata == SWRST_KEY);
  assign tx_push = wr && (bus_addr == A_TXD);
  assign rx_pop  = rd && (bus_addr == A_RXD);

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d[C_TXRST] = 1'b0;
    ctrl_d[C_RXRST] = 1'b0;
    ss_d            = ss_q;
    if (sw_rst) begin
      ctrl_d = CTRL_RST;
      ss_d   = '1;
    end else begin
      if (ctrl_wr) ctrl_d = bus_wdata[CTRL_W-1:0];
      if (wr && (bus_addr == A_SSEL)) ss_d = bus_wdata[NUM_SS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      ss_q   <= ss_d;
    end
  end

  assign tx_flush = ctrl_q[C_TXRST] || sw_rst;
  assign rx_flush = ctrl_q[C_RXRST] || sw_rst;
  assign go       = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_HOLD]
                    && !tx_empty && !tx_flush;

  always_comb begin
    eng_mode.cpol  = ctrl_q[C_CPOL];
    eng_mode.cpha  = ctrl_q[C_CPHA];
    eng_mode.lsb   = ctrl_q[C_LSB];
    eng_mode.loopb = ctrl_q[C_LOOP];
  end

  spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_s), .flush(tx_flush),
    .push(tx_push), .din(bus_wdata[DW-1:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_s), .flush(rx_flush),
    .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  spim_engine #(.DW(DW), .CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .clr(sw_rst), .go(go), .mode(eng_mode),
    .tx_word(tx_dout), .tx_pop(tx_pop), .rx_word(rx_word), .rx_push(rx_push),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy)
  );

  assign ss_n = (ctrl_q[C_MANSS] || eng_busy) ? ss_q : '1;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = 32'(ctrl_q);
      A_STAT:  bus_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      A_RXD:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_dout);
      A_SSEL:  bus_rdata = 32'(ss_q);
      default: bus_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/spim_chk.sv
module spim_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        hold,
  input logic        cpol,
  input logic        sclk,
  input logic        txrst_bit,
  input logic        ctrl_wr,
  input logic        clr,
  input logic        tx_full,
  input logic        tx_empty,
  input logic        tx_pop,
  input logic        rx_empty,
  input logic        rx_pop,
  input logic [31:0] bus_rdata
);

  a_r4_hold_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !busy |=> !busy);

  a_r5_sclk_rests_at_cpol: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(cpol) |-> sclk == cpol);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    txrst_bit |=> tx_empty);

  a_r9_flush_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    txrst_bit && !ctrl_wr |=> !txrst_bit);

  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && !tx_pop && !txrst_bit && !clr |=> tx_full);

  a_r11_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && rx_empty |-> bus_rdata == 32'd0);

endmodule

bind spi_fifo_master spim_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .busy(eng_busy), .hold(ctrl_q[8]),
  .cpol(ctrl_q[3]), .sclk(sclk), .txrst_bit(ctrl_q[5]), .ctrl_wr(ctrl_wr),
  .clr(sw_rst), .tx_full(tx_full), .tx_empty(tx_empty), .tx_pop(tx_pop),
  .rx_empty(rx_empty), .rx_pop(rx_pop), .bus_rdata(bus_rdata)
);

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;
  localparam int DW = 8, DEPTH = 4, DIV = 2, NSS = 4;
  localparam logic [7:0] A_SWRST = 8'h40, A_CTRL = 8'h60, A_STAT = 8'h64,
                         A_TXD = 8'h68, A_RXD = 8'h6C, A_SSEL = 8'h70;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bus_valid, bus_write, miso, sclk, mosi;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rv;
  logic [NSS-1:0] ss_n;

  spi_fifo_master #(.DW(DW), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV), .NUM_SS(NSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  int n_chk = 0, n_bad = 0;

  // target model: single writer of its own state
  logic       armed = 1'b0;
  logic       cfg_cpha = 1'b0;
  int         arm_cnt = 0, seen_arm = 0;
  int         e = 0, wc = 0, bidx = 0;
  logic [7:0] cap = 8'h00;
  logic [7:0] caps [16];
  logic [7:0] sbytes [16];
  realtime    t1 = 0, t16 = 0;

  assign miso = sbytes[wc][7-bidx];

  always @(sclk or arm_cnt) begin
    if (arm_cnt != seen_arm) begin
      seen_arm = arm_cnt; e = 0; wc = 0; bidx = 0;
    end else if (armed) begin
      e = e + 1;
      if (cfg_cpha ? (e % 2 == 0) : (e % 2 == 1)) cap = {cap[6:0], mosi};
      if (wc == 0 && e == 1)  t1 = $realtime;
      if (wc == 0 && e == 16) t16 = $realtime;
      if (e == 16) begin
        caps[wc] = cap; wc = wc + 1; e = 0; bidx = 0;
      end else if (cfg_cpha ? (e % 2 == 1 && e > 1) : (e % 2 == 0)) begin
        bidx = bidx + 1;
      end
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] tb_b [3];
    logic [31:0] c;
    int word_cyc;
    word_cyc = 2 * DW * DIV + 1;
    for (int k = 0; k < 16; k++) sbytes[k] = 8'h00;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    idle(3); rst_n = 1'b1; idle(4);

    // R1 reset state
    rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h180);
    rd(A_STAT, rv); check("R1 status", rv, 32'h05);
    rd(A_SSEL, rv); check("R1 select", rv, 32'h0F);
    check("R1 ss_n", 32'(ss_n), 32'h0F);
    check("R1 sclk", 32'(sclk), 32'h0);

    // R2 readback
    wr(A_CTRL, 32'h381); rd(A_CTRL, rv); check("R2 ctrl readback", rv, 32'h381);

    // R13 enable clear: no shifting
    wr(A_CTRL, 32'h005); wr(A_TXD, 32'h5A); idle(60);
    rd(A_STAT, rv); check("R13 queued without enable", rv, 32'h01);
    // R9 flush
    wr(A_CTRL, 32'h025); idle(2);
    rd(A_CTRL, rv); check("R9 flush bit self-clears", rv, 32'h005);
    rd(A_STAT, rv); check("R9 tx flushed", rv, 32'h05);

    // R4 hold
    wr(A_CTRL, 32'h187); wr(A_TXD, 32'hA5); idle(60);
    rd(A_STAT, rv); check("R4 held in queue", rv, 32'h01);
    check("R4 sclk quiet", 32'(sclk), 32'h0);
    wr(A_CTRL, 32'h087); idle(word_cyc + 10);
    rd(A_STAT, rv); check("R4 drained", rv, 32'h04);
    rd(A_RXD, rv); check("R8 loopback word", rv, 32'hA5);

    // R10 / R11 queue limits
    wr(A_CTRL, 32'h187);
    for (int i = 0; i < DEPTH + 2; i++) wr(A_TXD, 32'(8'h10 + i));
    rd(A_STAT, rv); check("R10 tx full", rv, 32'h09);
    wr(A_CTRL, 32'h087); idle((DEPTH + 2) * word_cyc + 10);
    rd(A_STAT, rv); check("R11 rx full", rv, 32'h06);
    wr(A_TXD, 32'h77); idle(word_cyc + 10);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, rv); check("R10 R11 kept words", rv, 32'(8'h10 + i));
    end
    rd(A_RXD, rv); check("R11 empty read zero", rv, 32'h0);
    rd(A_STAT, rv); check("R11 state unchanged", rv, 32'h05);

    // R3 select behaviour
    wr(A_SSEL, 32'h0B); wr(A_CTRL, 32'h007); idle(2);
    check("R3 auto idle", 32'(ss_n), 32'h0F);
    wr(A_TXD, 32'h33); idle(4);
    check("R3 auto active", 32'(ss_n), 32'h0B);
    idle(word_cyc + 6);
    check("R3 auto released", 32'(ss_n), 32'h0F);
    rd(A_RXD, rv); check("R8 auto word", rv, 32'h33);
    wr(A_CTRL, 32'h087); idle(1);
    check("R3 manual", 32'(ss_n), 32'h0B);

    // R12 soft reset
    wr(A_CTRL, 32'h081); wr(A_SWRST, 32'h0B);
    rd(A_CTRL, rv); check("R12 wrong key ignored", rv, 32'h081);
    wr(A_SSEL, 32'h03); wr(A_CTRL, 32'h29B); wr(A_SWRST, 32'h0A);
    rd(A_CTRL, rv); check("R12 ctrl reset", rv, 32'h180);
    rd(A_SSEL, rv); check("R12 select reset", rv, 32'h0F);
    rd(A_STAT, rv); check("R12 status reset", rv, 32'h05);

    // R5 R6 R7 R8 sweep over polarity, phase, order, loopback
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic cp, ch, ls, lp;
      cp = cfg[0]; ch = cfg[1]; ls = cfg[2]; lp = cfg[3];
      c = 32'h186 | 32'(lp) | (32'(cp) << 3) | (32'(ch) << 4) | (32'(ls) << 9);
      wr(A_CTRL, c); wr(A_SSEL, 32'h0E); idle(4);
      for (int k = 0; k < 3; k++) begin
        tb_b[k] = 8'(cfg * 53 + k * 29 + 7);
        sbytes[k] = 8'(~(cfg * 11 + k * 71));
      end
      cfg_cpha = ch; armed = 1'b1; arm_cnt = arm_cnt + 1;
      idle(1);
      for (int k = 0; k < 3; k++) wr(A_TXD, 32'(tb_b[k]));
      wr(A_CTRL, c & ~32'h100);
      idle(3 * word_cyc + 12);
      for (int k = 0; k < 3; k++) begin
        check("R6 R7 mosi bits", 32'(caps[k]), 32'(ls ? rev8(tb_b[k]) : tb_b[k]));
        rd(A_RXD, rv);
        check("R6 R8 received", rv,
              32'(lp ? tb_b[k] : (ls ? rev8(sbytes[k]) : sbytes[k])));
      end
      check("R5 idle level", 32'(sclk), 32'(cp));
      check("R5 edge span", 32'(int'(t16 - t1)), 32'(15 * DIV * 5));
      armed = 1'b0;
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule